// File: doc/BRIEF.md
# Multi-Unit Task Dispatcher

This block is a scheduler placed in front of a pool of identical processing units. A host sees two channels. On the write channel it asks for a free unit, fills that unit's 16-word memory with a task, and starts the unit by letting go of its request. On the read channel it asks for a unit that has finished, reads back whatever words it needs, and hands the unit back to the free pool by letting go of its request. Units may finish and be collected in any order.

Each channel uses the same handshake. An `ok` flag reports whether any unit qualifies. The host raises a request, and the block answers with `ready` once a unit is connected. The host then holds the request until it wants to release the unit. The unit is chosen by a round-robin pointer, one for each channel. Each pointer steps past the unit it has just granted. Each channel also exports the frame tag of the unit it is showing, and the read channel also exports that unit's final flag. This lets an outside scheduler chain tasks. A global abort returns every unit to the pool at once. Only serial loading is implemented.

The units are stand-ins. Each one holds its memory, waits a fixed number of cycles after it is started, and then reports that it is done. Unit i waits `BASE_LAT + i*LAT_STEP` cycles.

Top module: `task_dispatcher`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `ok_to_write` and `idle` are 1, and `ok_to_read`, `ready_to_write`, `ready_to_read` and `get_load_mode` are 0. Every unit memory word is cleared.
- R2: `ok_to_write` is 1 exactly when at least one unit is free. `ok_to_read` is 1 exactly when at least one unit has finished and has not yet been acknowledged. Neither flag depends on the requests.
- R3: If `write_req` is 1 at a clock edge where a free unit exists and abort is low, `ready_to_write` is 1 after that edge. If `write_req` falls before `ready_to_write` rises, nothing is granted.
- R4: A word is written into a unit's memory only on an edge where `write`, `write_req` and `ready_to_write` are all 1. The word goes to the granted unit at `wr_addr`. A `write` at any other time changes no unit.
- R5: The first edge that sees `write_req` low while `ready_to_write` is 1 drops `ready_to_write` and starts the granted unit. The unit later reports done.
- R6: `ready_to_read` rises only after an edge where `read_req` and `ok_to_read` were 1. While it is high, `read` at an edge loads `rd_data` with word `rd_addr` of the granted unit, visible after that edge.
- R7: The first edge that sees `read_req` low while `ready_to_read` is 1 drops `ready_to_read` and returns the unit to the free pool. No read cycles are required before this.
- R8: Each channel grants the first qualifying unit at or after its own pointer, wrapping from the last unit to unit 0. After a grant, the pointer moves to the unit that follows the granted one. The two pointers move independently.
- R9: `frame_id_w` is bits [7:0] of word 0 of the unit the write channel is showing. That unit is the granted one while `ready_to_write` is high, and otherwise the unit the channel would grant next. `frame_id_r` is bits [7:0` and `final_bit` is bit 15 of word 0 of the unit shown by the read channel, chosen by the same rule.
- R10: `idle` is 1 exactly when every unit is free. An edge that sees `abort` high frees every unit and drops both `ready` outputs. Aborted units need no read acknowledgement.
- R11: `get_load_mode` stays 0 whatever `set_load_mode` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| abort | input | 1 | Frees every unit; held until `idle` |
| set_load_mode | input | 1 | Load mode request (1 = parallel) |
| get_load_mode | output | 1 | Load mode in use; always serial (0) |
| idle | output | 1 | All units free |
| frame_id_w | output | 8 | Frame tag of the unit shown by the write channel |
| ok_to_write | output | 1 | At least one unit is free |
| write_req | input | 1 | Write channel request, held until release |
| ready_to_write | output | 1 | A unit is connected to the write channel |
| wr_addr | input | 4 | Word address for writes |
| wr_data | input | 32 | Write data |
| write | input | 1 | Write strobe |
| frame_id_r | output | 8 | Frame tag of the unit shown by the read channel |
| final_bit | output | 1 | Final flag of the unit shown by the read channel |
| ok_to_read | output | 1 | At least one finished unit awaits acknowledgement |
| read_req | input | 1 | Read channel request, held until release |
| ready_to_read | output | 1 | A unit is connected to the read channel |
| read | input | 1 | Read strobe |
| rd_addr | input | 4 | Word address for reads |
| rd_data | output | 32 | Read data, one cycle after `read` |

## Verification
The main function is exercised with four patterns.

- Sequential: a few tasks are submitted one at a time and collected in turn. This checks that each channel picks the unit its pointer reaches, and that the exported tags follow the grants.
- Fill: every unit is loaded until the pool is full. A write request is then raised and withdrawn while no unit is free, which shows that a cancelled request leaves every unit's memory untouched. One unit is then freed and reused while the others are still waiting, which separates independent pointers from a shared one.
- Acknowledge only, and abort: one unit is released without any read, and an abort is raised while units are busy. Both must return units to the pool with no stale finished unit left behind.
- Stray write: a write strobe with no grant must leave the visible tag unchanged.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

   // Word 0 of every unit memory carries the frame tag in [7:0]
   // and the final flag in bit 15; the channels export both.
   localparam int TAG_W     = 8;
   localparam int FINAL_BIT = 15;

   typedef enum logic [0:0] {
      CH_IDLE  = 1'b0,
      CH_GRANT = 1'b1
   } ch_state_e;

   typedef enum logic [1:0] {
      U_FREE = 2'd0,
      U_HELD = 2'd1,
      U_BUSY = 2'd2,
      U_DONE = 2'd3
   } unit_state_e;

endpackage

// File: rtl/dispatch_rr_pick.sv
// Finds the first set bit of qualify at or after base, wrapping around.
module dispatch_rr_pick #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     qualify,
   input  logic [IDX_W-1:0] base,
   output logic             found,
   output logic [IDX_W-1:0] pick
);

   generate
      if (N == 1) begin : g_single
         logic unused_base;
         assign unused_base = ^base;
         assign found = qualify[0];
         assign pick  = '0;
      end else begin : g_scan
         always_comb begin
            found = 1'b0;
            pick  = '0;
            // Scan from the far end so the closest candidate is taken last.
            for (int k = N - 1; k >= 0; k--) begin
               int unsigned      s;
               logic [IDX_W-1:0] si;
               s = int'(base) + k;
               if (s >= N) s = s - N;
               si = IDX_W'(s);
               if (qualify[si]) begin
                  found = 1'b1;
                  pick  = si;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dispatch_unit_stub.sv
// Stand-in processing unit: word memory plus a fixed-latency busy phase.
module dispatch_unit_stub
   import dispatch_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int LATENCY = 4,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              abort,
   input  logic              load,
   input  logic              run,
   input  logic              thanks,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   output logic [TAG_W-1:0]  head_tag,
   output logic              head_final,
   output logic              available,
   output logic              done
);

   localparam int WORDS = 1 << ADDR_W;

   unit_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (rst || abort) begin
         state <= U_FREE;
         cnt   <= '0;
      end else begin
         unique case (state)
            U_FREE: if (load) state <= U_HELD;
            U_HELD: if (run) begin
               state <= U_BUSY;
               cnt   <= CNT_W'(LATENCY - 1);
            end
            U_BUSY: begin
               if (cnt == '0) state <= U_DONE;
               else           cnt   <= cnt - 1'b1;
            end
            U_DONE: if (thanks) state <= U_FREE;
            default: state <= U_FREE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_word    = mem[rd_addr];
   assign head_tag   = mem[0][TAG_W-1:0];
   assign head_final = mem[0][FINAL_BIT];
   assign available  = (state == U_FREE);
   assign done       = (state == U_DONE);

endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher
   import dispatch_pkg::*;
#(
   parameter int NUM_UNITS     = 8,
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 32,
   parameter int BASE_LAT      = 4,
   parameter int LAT_STEP      = 3,
   parameter bit PARALLEL_LOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              abort,
   input  logic              set_load_mode,
   output logic              get_load_mode,
   output logic              idle,
   output logic [7:0]        frame_id_w,
   output logic              ok_to_write,
   input  logic              write_req,
   output logic              ready_to_write,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              write,
   output logic [7:0]        frame_id_r,
   output logic              final_bit,
   output logic              ok_to_read,
   input  logic              read_req,
   output logic              ready_to_read,
   input  logic              read,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int IDX_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
   localparam int LAT_MAX = BASE_LAT + (NUM_UNITS - 1) * LAT_STEP;
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   if (NUM_UNITS < 2)        begin : g_bad_units $error("NUM_UNITS must be at least 2"); end
   if (ADDR_W < 1)           begin : g_bad_addr  $error("ADDR_W must be at least 1"); end
   if (DATA_W <= FINAL_BIT)  begin : g_bad_data  $error("DATA_W too narrow for the header fields"); end
   if (BASE_LAT < 1)         begin : g_bad_lat   $error("BASE_LAT must be at least 1"); end
   if (LAT_STEP < 0)         begin : g_bad_step  $error("LAT_STEP must not be negative"); end
   if (TAG_W != 8)           begin : g_bad_tag   $error("frame tag ports are 8 bits"); end
   if (PARALLEL_LOAD != 1'b0) begin : g_bad_mode $error("parallel load is not implemented"); end

   function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
      step_idx = (i == IDX_W'(NUM_UNITS - 1)) ? '0 : i + 1'b1;
   endfunction

   logic [NUM_UNITS-1:0] unit_free, unit_done;
   logic [NUM_UNITS-1:0] load_v, run_v, thanks_v, wen_v;
   logic [DATA_W-1:0]    unit_rd   [NUM_UNITS];
   logic [TAG_W-1:0]     unit_tag  [NUM_UNITS];
   logic [NUM_UNITS-1:0] unit_final;

   // ---------------- write channel ----------------
   ch_state_e        w_state;
   logic [IDX_W-1:0] w_ptr, w_sel, w_pick, w_show;
   logic             w_found, w_grant_now, w_release;

   dispatch_rr_pick #(.N(NUM_UNITS), .IDX_W(IDX_W)) u_wpick (
      .qualify (unit_free),
      .base    (w_ptr),
      .found   (w_found),
      .pick    (w_pick)
   );

   assign w_grant_now = (w_state == CH_IDLE) && write_req && w_found && !abort;
   assign w_release   = (w_state == CH_GRANT) && !write_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         w_state <= CH_IDLE;
         w_ptr   <= '0;
         w_sel   <= '0;
      end else if (abort) begin
         w_state <= CH_IDLE;
      end else if (w_grant_now) begin
         w_state <= CH_GRANT;
         w_sel   <= w_pick;
         w_ptr   <= step_idx(w_pick);
      end else if (w_release) begin
         w_state <= CH_IDLE;
      end
   end

   // ---------------- read channel ----------------
   ch_state_e        r_state;
   logic [IDX_W-1:0] r_ptr, r_sel, r_pick, r_show;
   logic             r_found, r_grant_now, r_release;

   dispatch_rr_pick #(.N(NUM_UNITS), .IDX_W(IDX_W)) u_rpick (
      .qualify (unit_done),
      .base    (r_ptr),
      .found   (r_found),
      .pick    (r_pick)
   );

   assign r_grant_now = (r_state == CH_IDLE) && read_req && r_found && !abort;
   assign r_release   = (r_state == CH_GRANT) && !read_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         r_state <= CH_IDLE;
         r_ptr   <= '0;
         r_sel   <= '0;
      end else if (abort) begin
         r_state <= CH_IDLE;
      end else if (r_grant_now) begin
         r_state <= CH_GRANT;
         r_sel   <= r_pick;
         r_ptr   <= step_idx(r_pick);
      end else if (r_release) begin
         r_state <= CH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                             rd_data <= '0;
      else if (read && r_state == CH_GRANT) rd_data <= unit_rd[r_sel];
   end

   // ---------------- unit array ----------------
   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
      assign load_v[i]   = w_grant_now && (w_pick == IDX_W'(i));
      assign run_v[i]    = w_release && (w_sel == IDX_W'(i));
      assign wen_v[i]    = write && write_req && (w_state == CH_GRANT) && (w_sel == IDX_W'(i));
      assign thanks_v[i] = r_release && (r_sel == IDX_W'(i));

      dispatch_unit_stub #(
         .ADDR_W  (ADDR_W),
         .DATA_W  (DATA_W),
         .LATENCY (BASE_LAT + i * LAT_STEP),
         .CNT_W   (CNT_W)
      ) u_stub (
         .clk        (clk),
         .rst        (rst),
         .abort      (abort),
         .load       (load_v[i]),
         .run        (run_v[i]),
         .thanks     (thanks_v[i]),
         .wr_en      (wen_v[i]),
         .wr_addr    (wr_addr),
         .wr_data    (wr_data),
         .rd_addr    (rd_addr),
         .rd_word    (unit_rd[i]),
         .head_tag   (unit_tag[i]),
         .head_final (unit_final[i]),
         .available  (unit_free[i]),
         .done       (unit_done[i])
      );
   end

   // ---------------- status and exported tags ----------------
   assign ok_to_write    = |unit_free;
   assign ok_to_read     = |unit_done;
   assign idle           = &unit_free;
   assign ready_to_write = (w_state == CH_GRANT);
   assign ready_to_read  = (r_state == CH_GRANT);

   assign w_show     = (w_state == CH_GRANT) ? w_sel : w_pick;
   assign r_show     = (r_state == CH_GRANT) ? r_sel : r_pick;
   assign frame_id_w = unit_tag[w_show];
   assign frame_id_r = unit_tag[r_show];
   assign final_bit  = unit_final[r_show];

   logic load_mode_q;
   always_ff @(posedge clk) begin
      if (rst)       load_mode_q <= 1'b0;
      else if (idle) load_mode_q <= set_load_mode & PARALLEL_LOAD;
   end
   assign get_load_mode = load_mode_q;

endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker (
   input logic clk,
   input logic rst,
   input logic abort,
   input logic get_load_mode,
   input logic idle,
   input logic ok_to_write,
   input logic write_req,
   input logic ready_to_write,
   input logic ok_to_read,
   input logic read_req,
   input logic ready_to_read
);

   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ok_to_write && idle && !ok_to_read && !ready_to_write && !ready_to_read));

   a_r2_idle_flags: assert property (@(posedge clk) disable iff (rst)
      idle |-> (ok_to_write && !ok_to_read));

   a_r3_write_grant_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_to_write) |-> $past(write_req && ok_to_write));

   a_r5_write_release: assert property (@(posedge clk) disable iff (rst)
      (ready_to_write && !write_req) |=> !ready_to_write);

   a_r6_read_grant_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_to_read) |-> $past(read_req && ok_to_read));

   a_r7_read_release: assert property (@(posedge clk) disable iff (rst)
      (ready_to_read && !read_req) |=> !ready_to_read);

   a_r10_abort_frees: assert property (@(posedge clk) disable iff (rst)
      abort |=> (idle && !ready_to_write && !ready_to_read));

   a_r11_serial_only: assert property (@(posedge clk) disable iff (rst)
      !get_load_mode);

endmodule

bind task_dispatcher dispatch_checker u_chk (
   .clk            (clk),
   .rst            (rst),
   .abort          (abort),
   .get_load_mode  (get_load_mode),
   .idle           (idle),
   .ok_to_write    (ok_to_write),
   .write_req      (write_req),
   .ready_to_write (ready_to_write),
   .ok_to_read     (ok_to_read),
   .read_req       (read_req),
   .ready_to_read  (ready_to_read)
);

// File: tb/tb_task_dispatcher.sv
module tb_task_dispatcher;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        abort = 1'b0;
   logic        set_load_mode = 1'b0;
   logic        get_load_mode, idle;
   logic [7:0]  frame_id_w, frame_id_r;
   logic        ok_to_write, ready_to_write, ok_to_read, ready_to_read, final_bit;
   logic        write_req = 1'b0, write = 1'b0, read_req = 1'b0, read = 1'b0;
   logic [3:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   task_dispatcher dut (
      .clk(clk), .rst(rst), .abort(abort),
      .set_load_mode(set_load_mode), .get_load_mode(get_load_mode), .idle(idle),
      .frame_id_w(frame_id_w), .ok_to_write(ok_to_write), .write_req(write_req),
      .ready_to_write(ready_to_write), .wr_addr(wr_addr), .wr_data(wr_data), .write(write),
      .frame_id_r(frame_id_r), .final_bit(final_bit), .ok_to_read(ok_to_read),
      .read_req(read_req), .ready_to_read(ready_to_read), .read(read),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // scoreboard: expected {final, tag} and payload, in collection order
   logic [8:0]  exp_head_q [$];
   logic [31:0] exp_data_q [$];
   logic [31:0] mon_w0, mon_w3;
   event        got_ev;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: compares every collected result with the scoreboard head (R6)
   initial begin
      forever begin
         @(got_ev);
         if (exp_head_q.size() == 0) begin
            chk("R6", "unexpected result", 32'd1, 32'd0);
         end else begin
            logic [8:0]  eh;
            logic [31:0] ed;
            eh = exp_head_q.pop_front();
            ed = exp_data_q.pop_front();
            chk("R6", "read tag/final", {23'd0, mon_w0[15], mon_w0[7:0]}, {23'd0, eh});
            chk("R6", "read payload", mon_w3, ed);
         end
      end
   end

   task automatic submit(input logic [7:0] tag, input bit fin, input logic [31:0] payload,
                         input bit expect_fast, input bit keep);
      int waited = 0;
      @(negedge clk);
      write_req = 1'b1;
      do begin
         @(negedge clk);
         waited++;
      end while (!ready_to_write && waited < 50);
      if (expect_fast) chk("R3", "cycles to ready_to_write", waited, 1);
      write = 1'b1; wr_addr = 4'd0; wr_data = {16'h0, fin, 7'h0, tag};
      @(negedge clk);
      chk("R9", "frame_id_w after header write", {24'd0, frame_id_w}, {24'd0, tag});
      wr_addr = 4'd3; wr_data = payload;
      @(negedge clk);
      write = 1'b0; write_req = 1'b0;
      if (keep) begin
         exp_head_q.push_back({fin, tag});
         exp_data_q.push_back(payload);
      end
      @(negedge clk);
      chk("R5", "ready_to_write after release", {31'd0, ready_to_write}, 32'd0);
   endtask

   task automatic fetch(input bit do_reads);
      int waited = 0;
      @(negedge clk);
      read_req = 1'b1;
      do begin
         @(negedge clk);
         waited++;
      end while (!ready_to_read && waited < 50);
      chk("R6", "ready_to_read granted", {31'd0, ready_to_read}, 32'd1);
      if (do_reads) begin
         read = 1'b1; rd_addr = 4'd0;
         @(negedge clk);
         mon_w0 = rd_data;
         rd_addr = 4'd3;
         @(negedge clk);
         mon_w3 = rd_data;
         read = 1'b0;
         -> got_ev;
      end else begin
         // acknowledgement only: the result is dropped from the scoreboard (R7)
         void'(exp_head_q.pop_front());
         void'(exp_data_q.pop_front());
      end
      read_req = 1'b0;
      @(negedge clk);
      chk("R7", "ready_to_read after release", {31'd0, ready_to_read}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1", "ok_to_write", {31'd0, ok_to_write}, 32'd1);
      chk("R1", "ok_to_read", {31'd0, ok_to_read}, 32'd0);
      chk("R1", "idle", {31'd0, idle}, 32'd1);
      chk("R1", "ready outputs", {30'd0, ready_to_write, ready_to_read}, 32'd0);
      chk("R11", "get_load_mode after reset", {31'd0, get_load_mode}, 32'd0);

      // sequential tasks onto units 0..2
      submit(8'h11, 1'b1, 32'hA0A0_0001, 1'b1, 1'b1);
      chk("R10", "idle while busy", {31'd0, idle}, 32'd0);
      submit(8'h22, 1'b0, 32'hB0B0_0002, 1'b1, 1'b1);
      submit(8'h33, 1'b1, 32'hC0C0_0003, 1'b1, 1'b1);
      repeat (40) @(negedge clk);
      chk("R2", "ok_to_read after completion", {31'd0, ok_to_read}, 32'd1);
      chk("R9", "frame_id_r of unit 0", {24'd0, frame_id_r}, 32'h11);
      chk("R9", "final_bit of unit 0", {31'd0, final_bit}, 32'd1);
      fetch(1'b1);
      chk("R8", "read pointer moved to unit 1 tag", {24'd0, frame_id_r}, 32'h22);
      chk("R9", "final_bit of unit 1", {31'd0, final_bit}, 32'd0);
      fetch(1'b1);
      fetch(1'b1);
      chk("R7", "idle after all released", {31'd0, idle}, 32'd1);
      chk("R2", "ok_to_read after drain", {31'd0, ok_to_read}, 32'd0);

      // R4 stray write with no grant: next candidate (unit 3) must stay cleared
      @(negedge clk);
      write = 1'b1; wr_addr = 4'd0; wr_data = 32'h0000_00EE;
      @(negedge clk);
      write = 1'b0;
      @(negedge clk);
      chk("R4", "frame_id_w after stray write", {24'd0, frame_id_w}, 32'h00);

      // fill all eight units: grants go 3..7 then 0..2
      for (int k = 0; k < 8; k++) submit(8'h40 + 8'(k), k[0], 32'h4000_0000 + k, 1'b1, 1'b1);
      chk("R2", "ok_to_write when full", {31'd0, ok_to_write}, 32'd0);
      // R3 request with no free unit, then withdrawn
      @(negedge clk);
      write_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3", "no grant while full", {31'd0, ready_to_write}, 32'd0);
      write_req = 1'b0;
      repeat (40) @(negedge clk);
      fetch(1'b1);                         // unit 3, tag 0x40
      chk("R2", "ok_to_write after one release", {31'd0, ok_to_write}, 32'd1);
      chk("R8", "write pointer shows freed unit 3", {24'd0, frame_id_w}, 32'h40);
      submit(8'h50, 1'b0, 32'h5050_5050, 1'b1, 1'b1);   // reuses unit 3
      for (int k = 0; k < 7; k++) fetch(1'b1);           // units 4..7, 0..2
      repeat (20) @(negedge clk);
      fetch(1'b1);                                        // unit 3 again, tag 0x50

      // R7 acknowledge without reading
      submit(8'h60, 1'b1, 32'h6060_6060, 1'b1, 1'b1);    // unit 4
      repeat (30) @(negedge clk);
      fetch(1'b0);
      chk("R7", "idle after acknowledge-only", {31'd0, idle}, 32'd1);

      // R10 abort while two units are busy
      submit(8'h70, 1'b0, 32'h7070_7070, 1'b1, 1'b0);    // unit 5
      submit(8'h71, 1'b0, 32'h7171_7171, 1'b1, 1'b0);    // unit 6
      abort = 1'b1;
      @(negedge clk);
      chk("R10", "idle after abort", {31'd0, idle}, 32'd1);
      chk("R10", "ok_to_read after abort", {31'd0, ok_to_read}, 32'd0);
      abort = 1'b0;
      repeat (40) @(negedge clk);
      chk("R10", "aborted units never finish", {31'd0, ok_to_read}, 32'd0);
      submit(8'h72, 1'b1, 32'h7272_7272, 1'b1, 1'b1);    // unit 7
      repeat (40) @(negedge clk);
      fetch(1'b1);

      // R11 parallel request is refused
      set_load_mode = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "get_load_mode with request", {31'd0, get_load_mode}, 32'd0);
      set_load_mode = 1'b0;

      repeat (2) @(negedge clk);
      chk("R6", "scoreboard empty", exp_head_q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule